// File: doc/BRIEF.md
# Clock and Power Mode Controller

This block decides which clock drives the main clock tree of a small microcontroller and which clock domains receive their enable. It holds four registers behind a simple write/read port: a control register with one enable per peripheral domain and three power-mode request bits, a slow-clock register, a lock-time register and a PLL configuration register. The main source is reported as a select code: pass-through of the input clock, the slow divided clock, or the PLL output. The divided clock is reported as a one-cycle tick that marks each of its rising edges.

The run, idle, slow-idle and stop modes are entered by writing the control register. An interrupt returns any low-power mode to run. A lock counter models the settling time of the PLL after each power-up. Two interlocks protect the PLL. Its power bit may change only while the slow clock is selected. The slow selection may be dropped only once the PLL reports lock. Every source change is deferred to a divider tick, so the clock mux downstream always switches at a point where both clocks are low.

Top module: `clkpm_top`

## Requirements
- R1: After reset the control register reads 0x7ff8, the slow register 0x09, the lock register 0xfff6 and the PLL configuration 0x38080. The CPU enable is 1, all twelve peripheral enables are 1, the mode code is 0 and the main source code is 0.
- R2: Address 0 holds the 15-bit control register: bits 14..3 drive peripheral enables 11..0, bit 2 requests idle, bit 1 is the slow-idle option and bit 0 requests stop. Address 1 holds the slow register: bit 5 is PLL off, bit 4 is slow select and bits 3..0 are the divider N. Address 2 holds the 16-bit lock time and address 3 the 20-bit PLL configuration. Reads are zero-extended.
- R3: The slow tick pulses once every 2N input cycles when N is nonzero, and on every cycle when N is zero.
- R4: The main source code is 1 (slow) while slow select is set. Otherwise it is 2 (PLL) when the PLL configuration has been written and the PLL is locked. Otherwise it is 0 (input clock passed through).
- R5: The main source code changes only on the cycle after a slow tick.
- R6: A write to the slow register changes the PLL-off bit only if slow select was already set before that write.
- R7: A write that would clear slow select is ignored while the locked flag is low.
- R8: When the PLL power output rises, the locked flag stays low and rises L+1 cycles later, where L is the lock register value.
- R9: The mode code is 0 run, 1 idle, 2 slow-idle, 3 stop. A control write in run with no interrupt selects the new mode from the next cycle. A value of exactly 0x46 gives slow-idle. Otherwise bit 0 gives stop. Otherwise bit 2 gives idle.
- R10: The CPU enable is 1 only in run. The peripheral enables follow control bits 14..3 except in stop, where they and the slow tick are 0.
- R11: The PLL power output is 0 while PLL off is set or the mode is stop. Leaving stop restarts the lock wait.
- R12: An interrupt moves any low-power mode to run on the next edge and clears control bit 2, while bits 1 and 0 are kept. An interrupt in the same cycle as a mode-entry write cancels the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, also used for counting |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 20 | Write data |
| rdata_o | output | 20 | Read data for addr_i |
| irq_i | input | 1 | Enabled interrupt pending |
| pll_cfg_o | output | 20 | PLL configuration value |
| pll_pwr_o | output | 1 | PLL power enable |
| pll_locked_o | output | 1 | PLL lock wait elapsed |
| main_sel_o | output | 2 | Main source: 0 input, 1 slow, 2 PLL |
| slow_tick_o | output | 1 | Rising-edge marker of the slow clock |
| pm_state_o | output | 2 | Power mode code |
| cpu_ce_o | output | 1 | CPU clock enable |
| periph_ce_o | output | 12 | Peripheral clock enables |

## Verification
A mode-entry write to the control register and a wake-up interrupt can reach the block in the same cycle. The interrupt must win: the mode stays run and the stored idle bit reads back as zero, while a stop bit written in that cycle is kept. The bench drives both inputs on the same edge, once with an idle request and once with a stop request. It then compares the mode code, the enables and the read-back control value against a cycle-by-cycle behavioural model. The same model also covers the other overlap, a source change that must wait for the next divider tick while a lock wait is still in progress.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

   typedef enum logic [1:0] {
      PM_RUN    = 2'd0,
      PM_IDLE   = 2'd1,
      PM_SLIDLE = 2'd2,
      PM_STOP   = 2'd3
   } pm_state_e;

   typedef enum logic [1:0] {
      SRC_FIN  = 2'd0,
      SRC_SLOW = 2'd1,
      SRC_PLL  = 2'd2
   } src_e;

   localparam int unsigned ADDR_W = 2;
   localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
   localparam logic [ADDR_W-1:0] A_SLOW   = 2'd1;
   localparam logic [ADDR_W-1:0] A_LOCK   = 2'd2;
   localparam logic [ADDR_W-1:0] A_PLLCFG = 2'd3;

   // control-register bits with fixed meaning
   localparam int unsigned B_STOP  = 0;
   localparam int unsigned B_IDLE  = 2;
   localparam int unsigned B_PERIPH = 3;

endpackage

// File: rtl/clkpm_regs.sv
module clkpm_regs
   import clkpm_pkg::*;
#(
   parameter int unsigned N_PERIPH = 12,
   parameter int unsigned DIV_W    = 4,
   parameter int unsigned LOCK_W   = 16,
   parameter int unsigned CFG_W    = 20,
   parameter int unsigned DW       = 20,
   parameter logic [N_PERIPH+2:0] CTRL_RST = 15'h7ff8,
   parameter logic [DIV_W-1:0]    DIV_RST  = 4'h9,
   parameter logic [LOCK_W-1:0]   LOCK_RST = 16'hfff6,
   parameter logic [CFG_W-1:0]    CFG_RST  = 20'h38080
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   wr_i,
   input  logic [ADDR_W-1:0]      addr_i,
   input  logic [DW-1:0]          wdata_i,
   input  logic                   irq_i,
   input  logic                   locked_i,
   output logic [N_PERIPH+2:0]    ctrl_o,
   output logic [DIV_W-1:0]       div_o,
   output logic                   slow_sel_o,
   output logic                   pll_off_o,
   output logic [LOCK_W-1:0]      lock_o,
   output logic [CFG_W-1:0]       cfg_o,
   output logic                   cfg_done_o,
   output logic [DW-1:0]          rdata_o
);

   localparam int unsigned CTRL_W = N_PERIPH + 3;
   localparam int unsigned SLOW_W = DIV_W + 2;
   localparam int unsigned SEL_B  = DIV_W;
   localparam int unsigned OFF_B  = DIV_W + 1;

   initial begin : p_elab
      assert (CTRL_W <= DW && SLOW_W <= DW && LOCK_W <= DW && CFG_W <= DW)
         else $error("clkpm_regs: a register is wider than the data bus");
      assert (DIV_W >= 1 && N_PERIPH >= 1)
         else $error("clkpm_regs: divider and peripheral counts must be nonzero");
   end

   logic [CTRL_W-1:0] ctrl_q, ctrl_n;
   logic [DIV_W-1:0]  div_q;
   logic              sel_q, off_q, cfgd_q;
   logic [LOCK_W-1:0] lock_q;
   logic [CFG_W-1:0]  cfg_q;
   logic              wr_ctrl, wr_slow;

   assign wr_ctrl = wr_i && (addr_i == A_CTRL);
   assign wr_slow = wr_i && (addr_i == A_SLOW);

   always_comb begin
      ctrl_n = ctrl_q;
      if (wr_ctrl) ctrl_n = wdata_i[CTRL_W-1:0];
      if (irq_i)   ctrl_n[B_IDLE] = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= CTRL_RST;
         div_q  <= DIV_RST;
         sel_q  <= 1'b0;
         off_q  <= 1'b0;
         lock_q <= LOCK_RST;
         cfg_q  <= CFG_RST;
         cfgd_q <= 1'b0;
      end else begin
         ctrl_q <= ctrl_n;
         if (wr_slow) begin
            div_q <= wdata_i[DIV_W-1:0];
            if (sel_q) off_q <= wdata_i[OFF_B];
            if (wdata_i[SEL_B] || locked_i) sel_q <= wdata_i[SEL_B];
         end
         if (wr_i && addr_i == A_LOCK) lock_q <= wdata_i[LOCK_W-1:0];
         if (wr_i && addr_i == A_PLLCFG) begin
            cfg_q  <= wdata_i[CFG_W-1:0];
            cfgd_q <= 1'b1;
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_CTRL:  rdata_o[CTRL_W-1:0] = ctrl_q;
         A_SLOW:  rdata_o[SLOW_W-1:0] = {off_q, sel_q, div_q};
         A_LOCK:  rdata_o[LOCK_W-1:0] = lock_q;
         default: rdata_o[CFG_W-1:0]  = cfg_q;
      endcase
   end

   assign ctrl_o     = ctrl_q;
   assign div_o      = div_q;
   assign slow_sel_o = sel_q;
   assign pll_off_o  = off_q;
   assign lock_o     = lock_q;
   assign cfg_o      = cfg_q;
   assign cfg_done_o = cfgd_q;

   // R6: PLL power bit moves only under slow selection
   a_r6_off_needs_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(off_q) |-> $past(sel_q));
   // R7: slow selection drops only with lock reported
   a_r7_clear_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sel_q) |-> $past(locked_i));
   // R12: interrupt leaves no idle request behind
   a_r12_irq_clears_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i |=> !ctrl_q[B_IDLE]);

endmodule

// File: rtl/clkpm_lock.sv
module clkpm_lock #(
   parameter int unsigned        LOCK_W   = 16,
   parameter logic [LOCK_W-1:0]  LOCK_RST = 16'hfff6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pwr_i,
   input  logic [LOCK_W-1:0] lock_val_i,
   output logic              locked_o
);

   initial begin : p_elab
      assert (LOCK_W >= 1) else $error("clkpm_lock: LOCK_W must be nonzero");
   end

   logic [LOCK_W-1:0] cnt_q;
   logic              prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= LOCK_RST;
         prev_q <= 1'b1;
      end else begin
         prev_q <= pwr_i;
         if (pwr_i && !prev_q)  cnt_q <= lock_val_i;
         else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign locked_o = pwr_i && prev_q && (cnt_q == '0);

   // R8: lock is reported only after power has been up a full cycle
   a_r8_lock_after_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(locked_o) |-> $past(pwr_i));

endmodule

// File: rtl/clkpm_div.sv
module clkpm_div
   import clkpm_pkg::*;
#(
   parameter int unsigned DIV_W       = 4,
   parameter bit          SYNC_SWITCH = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] div_val_i,
   input  logic             stop_i,
   input  src_e             want_i,
   output logic             tick_o,
   output src_e             sel_o
);

   localparam int unsigned CNT_W = DIV_W + 1;

   initial begin : p_elab
      assert (DIV_W >= 1) else $error("clkpm_div: DIV_W must be nonzero");
   end

   logic [CNT_W-1:0] cnt_q, last;
   logic             tick_raw;
   src_e             sel_q;

   assign last     = {div_val_i, 1'b0} - CNT_W'(1);
   assign tick_raw = (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                cnt_q <= '0;
      else if (div_val_i == '0 || cnt_q >= last)  cnt_q <= '0;
      else                                        cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (SYNC_SWITCH) begin : g_sync
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)       sel_q <= SRC_FIN;
            else if (tick_raw) sel_q <= want_i;
         end
         // R5: a source change lands only right after a tick
         a_r5_switch_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !$stable(sel_q) |-> $past(tick_raw));
      end else begin : g_direct
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sel_q <= SRC_FIN;
            else         sel_q <= want_i;
         end
      end
   endgenerate

   assign tick_o = tick_raw && !stop_i;
   assign sel_o  = sel_q;

endmodule

// File: rtl/clkpm_mode.sv
module clkpm_mode
   import clkpm_pkg::*;
#(
   parameter int unsigned        CTRL_W      = 15,
   parameter logic [CTRL_W-1:0]  SLIDLE_CODE = 15'h0046
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_ctrl_i,
   input  logic [CTRL_W-1:0] wdata_i,
   input  logic              irq_i,
   output pm_state_e         state_o
);

   initial begin : p_elab
      assert (CTRL_W > B_PERIPH) else $error("clkpm_mode: control register too narrow");
   end

   pm_state_e st_q, st_n;

   always_comb begin
      st_n = st_q;
      if (st_q == PM_RUN) begin
         if (wr_ctrl_i && !irq_i) begin
            if (wdata_i == SLIDLE_CODE) st_n = PM_SLIDLE;
            else if (wdata_i[B_STOP])   st_n = PM_STOP;
            else if (wdata_i[B_IDLE])   st_n = PM_IDLE;
         end
      end else if (irq_i) begin
         st_n = PM_RUN;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= PM_RUN;
      else         st_q <= st_n;
   end

   assign state_o = st_q;

   // R12: interrupt always returns a sleeping core to run
   a_r12_wake_to_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q != PM_RUN && irq_i) |=> st_q == PM_RUN);
   // R9: slow-idle is reached only through the exact code
   a_r9_slidle_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == PM_RUN && wr_ctrl_i && wdata_i != SLIDLE_CODE) |=> st_q != PM_SLIDLE);

endmodule

// File: rtl/clkpm_top.sv
module clkpm_top
   import clkpm_pkg::*;
#(
   parameter int unsigned N_PERIPH    = 12,
   parameter int unsigned DIV_W       = 4,
   parameter int unsigned LOCK_W      = 16,
   parameter int unsigned CFG_W       = 20,
   parameter int unsigned DW          = 20,
   parameter bit          SYNC_SWITCH = 1'b1,
   parameter logic [N_PERIPH+2:0] CTRL_RST    = 15'h7ff8,
   parameter logic [N_PERIPH+2:0] SLIDLE_CODE = 15'h0046,
   parameter logic [DIV_W-1:0]    DIV_RST     = 4'h9,
   parameter logic [LOCK_W-1:0]   LOCK_RST    = 16'hfff6,
   parameter logic [CFG_W-1:0]    CFG_RST     = 20'h38080
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wr_i,
   input  logic [1:0]           addr_i,
   input  logic [DW-1:0]        wdata_i,
   output logic [DW-1:0]        rdata_o,
   input  logic                 irq_i,
   output logic [CFG_W-1:0]     pll_cfg_o,
   output logic                 pll_pwr_o,
   output logic                 pll_locked_o,
   output logic [1:0]           main_sel_o,
   output logic                 slow_tick_o,
   output logic [1:0]           pm_state_o,
   output logic                 cpu_ce_o,
   output logic [N_PERIPH-1:0]  periph_ce_o
);

   localparam int unsigned CTRL_W = N_PERIPH + 3;

   logic [CTRL_W-1:0] ctrl;
   logic [DIV_W-1:0]  div_val;
   logic              slow_sel, pll_off, cfg_done, locked, pwr, tick;
   logic [LOCK_W-1:0] lock_val;
   pm_state_e         state;
   src_e              want, sel;

   clkpm_regs #(
      .N_PERIPH (N_PERIPH), .DIV_W (DIV_W), .LOCK_W (LOCK_W), .CFG_W (CFG_W), .DW (DW),
      .CTRL_RST (CTRL_RST), .DIV_RST (DIV_RST), .LOCK_RST (LOCK_RST), .CFG_RST (CFG_RST)
   ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .irq_i      (irq_i),
      .locked_i   (locked),
      .ctrl_o     (ctrl),
      .div_o      (div_val),
      .slow_sel_o (slow_sel),
      .pll_off_o  (pll_off),
      .lock_o     (lock_val),
      .cfg_o      (pll_cfg_o),
      .cfg_done_o (cfg_done),
      .rdata_o    (rdata_o)
   );

   clkpm_mode #(.CTRL_W (CTRL_W), .SLIDLE_CODE (SLIDLE_CODE)) u_mode (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_ctrl_i (wr_i && addr_i == A_CTRL),
      .wdata_i   (wdata_i[CTRL_W-1:0]),
      .irq_i     (irq_i),
      .state_o   (state)
   );

   assign pwr = !pll_off && (state != PM_STOP);

   clkpm_lock #(.LOCK_W (LOCK_W), .LOCK_RST (LOCK_RST)) u_lock (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pwr_i      (pwr),
      .lock_val_i (lock_val),
      .locked_o   (locked)
   );

   always_comb begin
      if (slow_sel)                want = SRC_SLOW;
      else if (cfg_done && locked) want = SRC_PLL;
      else                         want = SRC_FIN;
   end

   clkpm_div #(.DIV_W (DIV_W), .SYNC_SWITCH (SYNC_SWITCH)) u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .div_val_i (div_val),
      .stop_i    (state == PM_STOP),
      .want_i    (want),
      .tick_o    (tick),
      .sel_o     (sel)
   );

   assign pll_pwr_o    = pwr;
   assign pll_locked_o = locked;
   assign main_sel_o   = sel;
   assign slow_tick_o  = tick;
   assign pm_state_o   = state;
   assign cpu_ce_o     = (state == PM_RUN);
   assign periph_ce_o  = (state == PM_STOP) ? '0 : ctrl[CTRL_W-1:B_PERIPH];

   // R11: no lock can be reported while stopped
   a_r11_no_lock_in_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == PM_STOP) |-> !locked);

endmodule

// File: tb/tb_clkpm_top.sv
module tb_clkpm_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [19:0] wdata = '0;
   logic        irq = 1'b0;
   logic [19:0] rdata, pll_cfg;
   logic        pll_pwr, pll_locked, slow_tick, cpu_ce;
   logic [1:0]  main_sel, pm_state;
   logic [11:0] periph_ce;

   always #10 clk = ~clk;

   clkpm_top dut (
      .clk_i (clk), .rst_ni (rst_n), .wr_i (wr), .addr_i (addr), .wdata_i (wdata),
      .rdata_o (rdata), .irq_i (irq), .pll_cfg_o (pll_cfg), .pll_pwr_o (pll_pwr),
      .pll_locked_o (pll_locked), .main_sel_o (main_sel), .slow_tick_o (slow_tick),
      .pm_state_o (pm_state), .cpu_ce_o (cpu_ce), .periph_ce_o (periph_ce)
   );

   int n_tot = 0;
   int n_fail = 0;
   bit cmp_en = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      n_tot++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
   endtask

   // behavioural reference model, advanced on every rising edge
   logic [14:0] m_ctrl;
   logic        m_off, m_ssel, m_cfgd, m_prev;
   logic [3:0]  m_div;
   logic [15:0] m_lock, m_cnt;
   int          m_st, m_sel, m_dc;
   logic        e_pwr, e_lk;
   int          e_want;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl = 15'h7ff8; m_off = 0; m_ssel = 0; m_div = 4'h9;
         m_lock = 16'hfff6; m_cnt = 16'hfff6; m_cfgd = 0; m_prev = 1;
         m_st = 0; m_sel = 0; m_dc = 0;
      end else begin
         e_pwr  = !m_off && m_st != 3;
         e_lk   = e_pwr && m_prev && m_cnt == 0;
         e_want = m_ssel ? 1 : ((m_cfgd && e_lk) ? 2 : 0);
         if (m_dc == 0) m_sel = e_want;
         if (m_div == 0 || m_dc >= 2 * int'(m_div) - 1) m_dc = 0;
         else m_dc = m_dc + 1;
         if (e_pwr && !m_prev) m_cnt = m_lock;
         else if (m_cnt != 0) m_cnt = m_cnt - 1;
         m_prev = e_pwr;
         if (m_st == 0) begin
            if (wr && addr == 2'd0 && !irq) begin
               if (wdata[14:0] == 15'h0046) m_st = 2;
               else if (wdata[0])           m_st = 3;
               else if (wdata[2])           m_st = 1;
            end
         end else if (irq) m_st = 0;
         if (wr) begin
            case (addr)
               2'd0: m_ctrl = wdata[14:0];
               2'd1: begin
                  if (m_ssel) m_off = wdata[5];
                  if (wdata[4] || e_lk) m_ssel = wdata[4];
                  m_div = wdata[3:0];
               end
               2'd2: m_lock = wdata[15:0];
               default: m_cfgd = 1;
            endcase
         end
         if (irq) m_ctrl[2] = 1'b0;
      end
   end

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         chk("R10 cpu_ce", int'(cpu_ce), int'(m_st == 0));
         chk("R10 periph_ce", int'(periph_ce), (m_st == 3) ? 0 : int'(m_ctrl[14:3]));
         chk("R11 pll_pwr", int'(pll_pwr), int'(!m_off && m_st != 3));
         chk("R8 locked", int'(pll_locked),
             int'(!m_off && m_st != 3 && m_prev && m_cnt == 0));
         chk("R4/R5 main_sel", int'(main_sel), m_sel);
         chk("R3 slow_tick", int'(slow_tick), int'(m_dc == 0 && m_st != 3));
         chk("R9 pm_state", int'(pm_state), m_st);
      end
   end

   task automatic wr_reg(input logic [1:0] a, input logic [19:0] d, input logic with_irq);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d; irq = with_irq;
      @(negedge clk);
      wr = 1'b0; irq = 1'b0;
   endtask

   task automatic pulse_irq();
      @(negedge clk);
      irq = 1'b1;
      @(negedge clk);
      irq = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
      @(negedge clk);
      addr = a;
      #5;
      chk(tag, int'(rdata), exp);
   endtask

   task automatic count_ticks(input string tag, input int cycles, input int exp);
      int n = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (slow_tick) n++;
      end
      chk(tag, n, exp);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_tot++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
   end

   initial begin : main
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      cmp_en = 1'b1;
      // R1 reset state
      rd_chk("R1 ctrl reset", 2'd0, 'h7ff8);
      rd_chk("R1 slow reset", 2'd1, 'h09);
      rd_chk("R1 lock reset", 2'd2, 'hfff6);
      rd_chk("R1 cfg reset", 2'd3, 'h38080);
      chk("R1 cpu_ce", int'(cpu_ce), 1);
      chk("R1 periph_ce", int'(periph_ce), 'hfff);
      chk("R1 main_sel", int'(main_sel), 0);
      chk("R1 pm_state", int'(pm_state), 0);
      // R3 divider ratios
      count_ticks("R3 N=9", 180, 10);
      wr_reg(2'd1, 20'h03, 1'b0);
      repeat (20) @(negedge clk);
      count_ticks("R3 N=3", 60, 10);
      wr_reg(2'd1, 20'h00, 1'b0);
      count_ticks("R3 N=0", 60, 60);
      // R6 power bit ignored without slow selection
      wr_reg(2'd1, 20'h23, 1'b0);
      rd_chk("R6 off ignored", 2'd1, 'h03);
      chk("R6 pll_pwr kept", int'(pll_pwr), 1);
      // R2 field map
      wr_reg(2'd0, 20'h0008, 1'b0);
      chk("R2 periph bit3->ce0", int'(periph_ce), 'h001);
      chk("R2 no mode change", int'(pm_state), 0);
      wr_reg(2'd0, 20'h7ff8, 1'b0);
      wr_reg(2'd2, 20'h0014, 1'b0);
      rd_chk("R2 lock readback", 2'd2, 'h14);
      wr_reg(2'd3, 20'h12345, 1'b0);
      rd_chk("R2 cfg readback", 2'd3, 'h12345);
      chk("R2 cfg out", int'(pll_cfg), 'h12345);
      // R6/R7/R8 interlocks and relock
      wr_reg(2'd1, 20'h13, 1'b0);
      wr_reg(2'd1, 20'h33, 1'b0);
      chk("R6 off accepted", int'(pll_pwr), 0);
      wr_reg(2'd1, 20'h13, 1'b0);
      wr_reg(2'd1, 20'h03, 1'b0);
      rd_chk("R7 clear ignored", 2'd1, 'h13);
      repeat (30) @(negedge clk);
      chk("R8 locked", int'(pll_locked), 1);
      wr_reg(2'd1, 20'h03, 1'b0);
      rd_chk("R7 clear accepted", 2'd1, 'h03);
      repeat (10) @(negedge clk);
      chk("R4 on PLL", int'(main_sel), 2);
      // R9/R12 idle
      wr_reg(2'd0, 20'h7ffc, 1'b0);
      chk("R9 idle", int'(pm_state), 1);
      chk("R10 idle cpu off", int'(cpu_ce), 0);
      repeat (5) @(negedge clk);
      pulse_irq();
      chk("R12 woke", int'(pm_state), 0);
      rd_chk("R12 idle bit cleared", 2'd0, 'h7ff8);
      // R9 near miss and exact slow-idle code
      wr_reg(2'd0, 20'h004e, 1'b0);
      chk("R9 0x4e is idle", int'(pm_state), 1);
      pulse_irq();
      wr_reg(2'd0, 20'h0046, 1'b0);
      chk("R9 slow-idle", int'(pm_state), 2);
      chk("R10 slow-idle periph", int'(periph_ce), 'h008);
      pulse_irq();
      rd_chk("R12 slow-idle bit kept", 2'd0, 'h0042);
      // R11 stop and relock
      wr_reg(2'd0, 20'h7ff9, 1'b0);
      chk("R11 stop pwr", int'(pll_pwr), 0);
      chk("R10 stop periph", int'(periph_ce), 0);
      repeat (10) @(negedge clk);
      chk("R10 stop no tick", int'(slow_tick), 0);
      pulse_irq();
      rd_chk("R12 stop bit kept", 2'd0, 'h7ff9);
      repeat (40) @(negedge clk);
      chk("R11 relocked", int'(pll_locked), 1);
      wr_reg(2'd0, 20'h7ff8, 1'b0);
      // R12 collisions of entry write and interrupt
      wr_reg(2'd0, 20'h7ffc, 1'b1);
      chk("R12 idle entry cancelled", int'(pm_state), 0);
      rd_chk("R12 idle bit dropped", 2'd0, 'h7ff8);
      wr_reg(2'd0, 20'h7ff9, 1'b1);
      chk("R12 stop entry cancelled", int'(pm_state), 0);
      rd_chk("R12 stop bit stored", 2'd0, 'h7ff9);
      wr_reg(2'd0, 20'h7ff8, 1'b0);
      repeat (30) @(negedge clk);
      cmp_en = 1'b0;
      summary();
      $finish;
   end

endmodule